// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters and hands them to a host through a one-deep receive buffer. The line is sampled on a 16x oversampling clock enable. A start condition is confirmed at mid-bit. After that, each data bit, the optional parity bit and each stop bit is sampled once at the centre of its bit period. When the last stop bit has been sampled, the assembled character moves from the shift register into the buffer, and a one-cycle receive interrupt is raised.

The frame format is set with three independent controls: character length (7, 8 or 9 bits), parity (none, even or odd) and stop count (one or two). The block records three error conditions: overrun, framing error and parity error. An error-sum output reports the three together. The overrun decision is made when the bit just before the stop bit is sampled while the previous character is still unread. In that case the new character still overwrites the buffer, but no interrupt is raised for it.

An optional flow-control output tells the remote sender whether the receiver can accept another character.

Top module: `uart_rx_err`

## Requirements
- R1: While rx_en_i is 0 the receiver stays idle: a frame sent on the line is not received, and no interrupt or buffer update occurs.
- R2: A falling edge starts a frame only if the line is still low at the 8th oversampling tick. A shorter low pulse is discarded, and the receiver returns to idle without receiving anything.
- R3: data_len_i selects the character length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits. Bits arrive LSB first and are right-aligned on rdata_o, with the unused upper bits set to 0. Parity follows the character when par_en_i is 1. stop2_i selects two stop bits.
- R4: When the last stop bit is sampled, rdata_o takes the new character, full_o goes to 1, and irq_o pulses for exactly one clock.
- R5: If full_o is still 1 when the bit before the stop bit is sampled, ovr_err_o is set. The new character still replaces rdata_o, but irq_o does not pulse for it.
- R6: frm_err_o is set when any configured stop bit is sampled low.
- R7: With par_en_i at 1, par_err_o is set when the number of ones in the data bits plus the parity bit is odd in even mode (par_odd_i=0) or even in odd mode (par_odd_i=1).
- R8: err_sum_o is 1 exactly when at least one of ovr_err_o, frm_err_o and par_err_o is 1.
- R9: A one-cycle rd_i pulse clears full_o and all error flags.
- R10: Dropping rx_en_i clears all error flags. The buffer contents and full_o are kept.
- R11: With rts_en_i at 1, rts_o is 0 while rx_en_i is 1 and full_o is 0, and 1 otherwise. With rts_en_i at 0, rts_o is 0.
- R12: Only clock cycles with tick_i at 1 advance the receiver. A slower tick rate stretches the bit period by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| data_len_i | input | 2 | Character length: 0=7, 1=8, 2=9 bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| stop2_i | input | 1 | Two stop bits when 1 |
| rd_i | input | 1 | Host read strobe |
| rts_en_i | input | 1 | Enables the flow-control output |
| rdata_o | output | 9 | Receive buffer |
| full_o | output | 1 | Buffer holds an unread character |
| ovr_err_o | output | 1 | Overrun error |
| frm_err_o | output | 1 | Framing error |
| par_err_o | output | 1 | Parity error |
| err_sum_o | output | 1 | OR of the three error flags |
| rts_o | output | 1 | Ready-to-receive, active low |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
Every combination of length, parity mode and stop count is swept with all-zero, all-one, alternating and pseudo-random characters. Alternating patterns expose bit-order and alignment faults, and the all-one and all-zero cases separate parity sense from stuck data. Frames with a flipped parity bit, a low first stop bit and a low second stop bit show that each error flag responds only to its own cause. Two back-to-back unread frames show the overrun path, with the buffer overwritten and no interrupt. A short low glitch, a frame sent while disabled and a frame at a slowed tick rate test start qualification, gating and tick scaling.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [1:0] {LEN_7 = 2'd0, LEN_8 = 2'd1, LEN_9 = 2'd2} len_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_st_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                frm_err;
    logic                par_err;
  } rx_res_t;

  function automatic logic [3:0] len_bits(len_e l);
    case (l)
      LEN_7:   return 4'd7;
      LEN_9:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= '1;
        else         r_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= '1;
        else         r_q <= {r_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    rxd_i,
  input  logic    rx_en_i,
  input  len_e    len_i,
  input  logic    par_en_i,
  input  logic    par_odd_i,
  input  logic    stop2_i,
  output logic    busy_o,
  output logic    pre_stop_o,
  output logic    done_o,
  output rx_res_t res_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(MAX_BITS + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_st_e              st_q;
  logic [CW-1:0]       cnt_q;
  logic [BW-1:0]       idx_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                acc_q, stop_bad_q;
  rx_res_t             res_q;

  logic [3:0] nbits;
  logic [3:0] shamt;
  logic       last_data;

  assign nbits     = len_bits(len_i);
  assign shamt     = 4'(MAX_BITS) - nbits;
  assign last_data = (idx_q == BW'(nbits - 4'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      acc_q      <= 1'b0;
      stop_bad_q <= 1'b0;
      res_q      <= '0;
      pre_stop_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      pre_stop_o <= 1'b0;
      done_o     <= 1'b0;
      if (!rx_en_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (tick_i && !rxd_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
          ST_START: if (tick_i) begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (!rxd_i) begin
                st_q       <= ST_DATA;
                idx_q      <= '0;
                acc_q      <= 1'b0;
                stop_bad_q <= 1'b0;
              end else begin
                st_q <= ST_IDLE;  // glitch
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: if (tick_i) begin
            if (cnt_q != LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              case (st_q)
                ST_DATA: begin
                  sh_q  <= {rxd_i, sh_q[MAX_BITS-1:1]};
                  acc_q <= acc_q ^ rxd_i;
                  idx_q <= idx_q + 1'b1;
                  if (last_data) begin
                    st_q       <= par_en_i ? ST_PAR : ST_STOP1;
                    pre_stop_o <= !par_en_i;
                  end
                end
                ST_PAR: begin
                  acc_q      <= acc_q ^ rxd_i;
                  pre_stop_o <= 1'b1;
                  st_q       <= ST_STOP1;
                end
                ST_STOP1: begin
                  if (stop2_i) begin
                    stop_bad_q <= !rxd_i;
                    st_q       <= ST_STOP2;
                  end else begin
                    res_q.data    <= sh_q >> shamt;
                    res_q.frm_err <= !rxd_i;
                    res_q.par_err <= par_en_i & (acc_q ^ par_odd_i);
                    done_o        <= 1'b1;
                    st_q          <= ST_IDLE;
                  end
                end
                ST_STOP2: begin
                  res_q.data    <= sh_q >> shamt;
                  res_q.frm_err <= stop_bad_q | !rxd_i;
                  res_q.par_err <= par_en_i & (acc_q ^ par_odd_i);
                  done_o        <= 1'b1;
                  st_q          <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign res_o  = res_q;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_en_i,
  input  logic                rd_i,
  input  logic                rts_en_i,
  input  logic                pre_stop_i,
  input  logic                done_i,
  input  rx_res_t             res_i,
  output logic [MAX_BITS-1:0] rdata_o,
  output logic                full_o,
  output logic                ovr_err_o,
  output logic                frm_err_o,
  output logic                par_err_o,
  output logic                err_sum_o,
  output logic                rts_o,
  output logic                irq_o
);
  logic ovr_hit_q;
  logic rd_eff;

  assign rd_eff = rd_i && full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      full_o    <= 1'b0;
      ovr_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      par_err_o <= 1'b0;
      ovr_hit_q <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (!rx_en_i) begin
        ovr_err_o <= 1'b0;
        frm_err_o <= 1'b0;
        par_err_o <= 1'b0;
        ovr_hit_q <= 1'b0;
      end else begin
        if (rd_eff) begin
          full_o    <= 1'b0;
          ovr_err_o <= 1'b0;
          frm_err_o <= 1'b0;
          par_err_o <= 1'b0;
        end
        if (pre_stop_i) begin
          ovr_hit_q <= full_o && !rd_i;
          if (full_o && !rd_i) ovr_err_o <= 1'b1;
        end
        if (done_i) begin
          rdata_o   <= res_i.data;
          full_o    <= 1'b1;
          frm_err_o <= (frm_err_o & !rd_eff) | res_i.frm_err;
          par_err_o <= (par_err_o & !rd_eff) | res_i.par_err;
          irq_o     <= !ovr_hit_q;
          ovr_hit_q <= 1'b0;
        end
      end
    end
  end

  assign err_sum_o = ovr_err_o | frm_err_o | par_err_o;
  assign rts_o     = rts_en_i & !(rx_en_i & !full_o);
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  logic                rx_en_i,
  input  logic [1:0]          data_len_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                stop2_i,
  input  logic                rd_i,
  input  logic                rts_en_i,
  output logic [MAX_BITS-1:0] rdata_o,
  output logic                full_o,
  output logic                ovr_err_o,
  output logic                frm_err_o,
  output logic                par_err_o,
  output logic                err_sum_o,
  output logic                rts_o,
  output logic                irq_o
);
  logic    rxd_s;
  logic    busy_w, pre_stop_w, done_w;
  rx_res_t res_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_rx_engine #(.OSR(OSR)) engine_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rxd_i     (rxd_s),
    .rx_en_i   (rx_en_i),
    .len_i     (len_e'(data_len_i)),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .stop2_i   (stop2_i),
    .busy_o    (busy_w),
    .pre_stop_o(pre_stop_w),
    .done_o    (done_w),
    .res_o     (res_w)
  );

  uart_rx_hold hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en_i),
    .rd_i      (rd_i),
    .rts_en_i  (rts_en_i),
    .pre_stop_i(pre_stop_w),
    .done_i    (done_w),
    .res_i     (res_w),
    .rdata_o   (rdata_o),
    .full_o    (full_o),
    .ovr_err_o (ovr_err_o),
    .frm_err_o (frm_err_o),
    .par_err_o (par_err_o),
    .err_sum_o (err_sum_o),
    .rts_o     (rts_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic rd_i,
  input logic irq_o,
  input logic full_o,
  input logic ovr_err_o,
  input logic err_sum_o,
  input logic done_w,
  input logic busy_w
);
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !busy_w); // R1
  AST_IRQ_WITH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o); // R4
  AST_FULL_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(done_w)); // R4
  AST_NO_IRQ_ON_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !ovr_err_o); // R5
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(full_o)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rx_en_i && !done_w) |=> (!full_o && !err_sum_o)); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !err_sum_o); // R10
endmodule

bind uart_rx_err uart_rx_err_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .rd_i     (rd_i),
  .irq_o    (irq_o),
  .full_o   (full_o),
  .ovr_err_o(ovr_err_o),
  .err_sum_o(err_sum_o),
  .done_w   (done_w),
  .busy_w   (busy_w)
);

// File: tb/uart_rx_err_tb_top.sv
`timescale 1ns/1ps
module uart_rx_err_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic [1:0] len = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic       rd = 1'b0, rts_en = 1'b0;
  logic [8:0] rdata;
  logic       full, ovr, frm, par, esum, rts, irq;

  int checks = 0, errors = 0, irq_cnt = 0, tick_div = 1, tick_ph = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_err dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .rx_en_i(rx_en),
    .data_len_i(len), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .rd_i(rd), .rts_en_i(rts_en), .rdata_o(rdata), .full_o(full),
    .ovr_err_o(ovr), .frm_err_o(frm), .par_err_o(par), .err_sum_o(esum),
    .rts_o(rts), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (tick_ph >= tick_div - 1) tick_ph = 0; else tick_ph = tick_ph + 1;
    tick = (tick_ph == 0);
    if (rst_n && irq) irq_cnt = irq_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    rxd = b;
    wait_n(16 * tick_div);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic config_fmt(input int nb, input int pm, input bit s2);
    len = 2'(nb - 7); par_en = (pm != 0); par_odd = (pm == 2); stop2 = s2;
  endtask

  task automatic send(input logic [8:0] d, input int nb, input int pm, input bit s2,
                      input bit flip, input bit bad1, input bit bad2);
    int ones;
    logic pb;
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    pb = (pm == 2) ? ~ones[0] : ones[0];
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (pm != 0) bit_out(pb ^ flip);
    bit_out(!bad1);
    if (s2) bit_out(!bad2);
    rxd = 1'b1;
    wait_n(4);
  endtask

  task automatic host_read;
    rd = 1'b1;
    wait_n(1);
    rd = 1'b0;
    wait_n(1);
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int base;
    logic [8:0] m, v;
    wait_n(3);
    check("R4 reset full", 32'(full), 0);
    check("R8 reset err_sum", 32'(esum), 0);
    check("R4 reset irq", 32'(irq), 0);
    rst_n = 1'b1;
    wait_n(2);

    // R1: disabled receiver ignores a frame
    config_fmt(8, 0, 0);
    base = irq_cnt;
    send(9'h5A, 8, 0, 0, 0, 0, 0);
    wait_n(8);
    check("R1 disabled full", 32'(full), 0);
    check("R1 disabled irq", 32'(irq_cnt - base), 0);

    // R11 with receiver off and on
    rts_en = 1'b1;
    wait_n(1);
    check("R11 rts disabled rx", 32'(rts), 1);
    rx_en = 1'b1;
    wait_n(20);
    check("R11 rts empty", 32'(rts), 0);

    // R3/R4/R8/R9/R11 sweep
    for (int nb = 7; nb <= 9; nb++)
      for (int pm = 0; pm < 3; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int k = 0; k < 5; k++) begin
            m = 9'((1 << nb) - 1);
            case (k)
              0: v = 9'h000;
              1: v = m;
              2: v = 9'h155 & m;
              3: v = 9'h0AA & m;
              default: v = 9'(nb * 37 + pm * 11 + s2 * 5 + 1) & m;
            endcase
            config_fmt(nb, pm, s2[0]);
            base = irq_cnt;
            send(v, nb, pm, s2[0], 0, 0, 0);
            check("R3 data", 32'(rdata), 32'(v));
            check("R4 full", 32'(full), 1);
            check("R4 irq once", 32'(irq_cnt - base), 1);
            check("R8 no error", 32'(esum), 0);
            check("R11 rts full", 32'(rts), 1);
            host_read();
            check("R9 read clears full", 32'(full), 0);
            wait_n(16);
          end

    // R7 even parity error
    config_fmt(8, 1, 0);
    base = irq_cnt;
    send(9'h0B3, 8, 1, 0, 1, 0, 0);
    check("R7 even par_err", 32'(par), 1);
    check("R7 data kept", 32'(rdata), 32'h0B3);
    check("R6 no frm", 32'(frm), 0);
    check("R8 sum par", 32'(esum), 1);
    check("R4 irq with error", 32'(irq_cnt - base), 1);
    host_read();
    check("R9 par cleared", 32'(par), 0);
    wait_n(16);

    // R7 odd parity, 7 bits, 2 stops
    config_fmt(7, 2, 1);
    send(9'h041, 7, 2, 1, 1, 0, 0);
    check("R7 odd par_err", 32'(par), 1);
    check("R3 7-bit data", 32'(rdata), 32'h041);
    host_read();
    wait_n(16);

    // R6 framing, one stop
    config_fmt(8, 0, 0);
    base = irq_cnt;
    send(9'h0E7, 8, 0, 0, 0, 1, 0);
    check("R6 frm one stop", 32'(frm), 1);
    check("R8 sum frm", 32'(esum), 1);
    check("R7 no par", 32'(par), 0);
    wait_n(48);
    check("R2 low stop tail ignored", 32'(irq_cnt - base), 1);
    host_read();
    check("R9 frm cleared", 32'(frm), 0);
    wait_n(16);

    // R6 framing, second stop low
    config_fmt(9, 0, 1);
    send(9'h1C4, 9, 0, 1, 0, 0, 1);
    check("R6 frm second stop", 32'(frm), 1);
    check("R3 9-bit data", 32'(rdata), 32'h1C4);
    wait_n(48);
    host_read();
    wait_n(16);

    // R5 overrun
    config_fmt(8, 0, 0);
    base = irq_cnt;
    send(9'h03C, 8, 0, 0, 0, 0, 0);
    wait_n(16);
    send(9'h0C3, 8, 0, 0, 0, 0, 0);
    check("R5 ovr set", 32'(ovr), 1);
    check("R5 overwritten", 32'(rdata), 32'h0C3);
    check("R5 irq suppressed", 32'(irq_cnt - base), 1);
    check("R8 sum ovr", 32'(esum), 1);
    host_read();
    check("R9 ovr cleared", 32'(ovr), 0);
    check("R9 full cleared", 32'(full), 0);
    wait_n(16);

    // R10 disable clears errors, keeps buffer
    config_fmt(8, 1, 0);
    send(9'h071, 8, 1, 0, 1, 0, 0);
    check("R7 pre-disable par_err", 32'(par), 1);
    rx_en = 1'b0;
    wait_n(2);
    check("R10 errors cleared", 32'(esum), 0);
    check("R10 full kept", 32'(full), 1);
    check("R10 data kept", 32'(rdata), 32'h071);
    rx_en = 1'b1;
    host_read();
    wait_n(16);

    // R2 glitch rejected
    config_fmt(8, 0, 0);
    base = irq_cnt;
    rxd = 1'b0;
    wait_n(4);
    rxd = 1'b1;
    wait_n(40);
    check("R2 glitch no buffer", 32'(full), 0);
    check("R2 glitch no irq", 32'(irq_cnt - base), 0);
    send(9'h096, 8, 0, 0, 0, 0, 0);
    check("R2 frame after glitch", 32'(rdata), 32'h096);
    host_read();
    wait_n(16);

    // R12 slower tick
    tick_div = 3;
    config_fmt(9, 2, 1);
    base = irq_cnt;
    send(9'h1A5, 9, 2, 1, 0, 0, 0);
    check("R12 slow tick data", 32'(rdata), 32'h1A5);
    check("R12 slow tick irq", 32'(irq_cnt - base), 1);
    check("R12 slow tick no err", 32'(esum), 0);
    host_read();
    tick_div = 1;
    wait_n(16);

    // R11 flow control off
    rts_en = 1'b0;
    wait_n(1);
    check("R11 rts off", 32'(rts), 0);

    finish_run();
  end
endmodule